// File: doc/BRIEF.md
# Four-Channel Stereo Mixer with Control Decode

This block sits between the system's control bus and four sound-channel sequencers. It holds three control words in registers, each loaded by its own write strobe from a shared data bus. It splits those words into per-channel bits: a DMA enable, an attach-period flag, an attach-volume flag and an interrupt-pending flag. The attach flags are also passed down a fixed chain, so that channel n+1 is told when channel n sends it period or volume data. A channel's interrupt request input sets that channel's pending flag, and the flag stays set until a pending-word write clears it.

On each sample tick the block takes four signed 8-bit channel levels and four volume-gate bits. Channels 1 and 2 form the left sample and channels 0 and 3 form the right sample. A level counts only while its gate is high. Each pair sum is scaled by 128 into a signed 16-bit sample. A two-state sequencer presents both samples together one cycle after the tick, with a single-cycle strobe.

The sequencer has two states. MX_IDLE means no sample is being presented. MX_EMIT means a sample is being presented. The transitions are: MX_IDLE to MX_EMIT on a tick; MX_EMIT to MX_EMIT on a tick in the next cycle (back-to-back samples); MX_EMIT to MX_IDLE when no tick arrives; MX_IDLE to MX_IDLE otherwise.

Top module: `quad_audio_mixer`

## Requirements
- R1: After reset, every control output, both samples and the strobe are zero.
- R2: A cycle with `en_wr` high loads bits [3:0] of `wr_data` into `dma_en` (bit n is channel n), visible in the next cycle. Bits [15:4] are ignored and the other control registers keep their values.
- R3: A cycle with `mod_wr` high loads `att_per` from `wr_data[7:4]` and `att_vol` from `wr_data[3:0]` (bit n of each field is channel n), visible in the next cycle. Bits [15:8] are ignored.
- R4: `per_from_up[n]` equals `att_per[n-1]` and `vol_from_up[n]` equals `att_vol[n-1]` for n = 1..3. Bit 0 of both is always 0. The channel 3 flags reach no output of the chain.
- R5: A cycle with `pend_wr` high loads `pend` from `wr_data[3:0]` in the next cycle.
- R6: `irq_req[n]` high sets `pend[n]` in the next cycle. The bit holds until a pending write clears it. When a request and a pending write fall in the same cycle, the request bit wins, so `pend` becomes `wr_data[3:0] | irq_req`.
- R7: `valid` is high for exactly one cycle, in the cycle after each cycle with `tick` high. It is never high otherwise, and back-to-back ticks give back-to-back strobes.
- R8: `left` equals (gated level of channel 1 + gated level of channel 2) × 128 as a signed 16-bit value, taken at the tick. A gated level is the level when `gate[n]` is 1, and 0 otherwise. The level of channel n is `levels[8n+7:8n]`, in two's complement.
- R9: `right` is formed in the same way from channels 0 and 3.
- R10: `left` and `right` hold their values in every cycle without `valid`.
- R11: The sums reach the ends of the range: both levels at -128 give -32768, and both at 127 give 32512.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_wr | input | 1 | Load the DMA-enable register |
| mod_wr | input | 1 | Load the attach-flag register |
| pend_wr | input | 1 | Load the interrupt-pending register |
| wr_data | input | 16 | Shared write data |
| irq_req | input | 4 | Per-channel interrupt requests |
| tick | input | 1 | Sample tick |
| levels | input | 32 | Four signed 8-bit levels, channel n at [8n+7:8n] |
| gate | input | 4 | Per-channel volume gate |
| dma_en | output | 4 | Per-channel DMA enable |
| att_per | output | 4 | Per-channel attach-period flag |
| att_vol | output | 4 | Per-channel attach-volume flag |
| pend | output | 4 | Per-channel interrupt pending |
| per_from_up | output | 4 | Period data arrives from the channel below |
| vol_from_up | output | 4 | Volume data arrives from the channel below |
| left | output | 16 | Left signed sample |
| right | output | 16 | Right signed sample |
| valid | output | 1 | One-cycle strobe for the sample pair |

## Verification
Two functions can act on the pending register in the same cycle: a software write of the pending word and a channel's interrupt request. The bench drives `pend_wr` and `irq_req` in the same cycle, with write data that clears the requested bit. It then checks that the requested bit reads 1 and the other bits follow the write data. In the mixer, a tick in the cycle right after another tick causes an MX_EMIT to MX_EMIT step. The scoreboard checks that each of the two sample pairs arrives in order, one cycle after its own tick.

// File: rtl/quad_audio_mixer_pkg.sv
package quad_audio_mixer_pkg;
    localparam int NUM_CH   = 4;
    localparam int LVL_W    = 8;
    localparam int SMP_W    = 16;
    localparam int SCALE_SH = 7;
    localparam int WORD_W   = 16;

    typedef enum logic [0:0] {
        MX_IDLE = 1'b0,
        MX_EMIT = 1'b1
    } mix_state_t;
endpackage

// File: rtl/quad_audio_mixer_ctrl.sv
module quad_audio_mixer_ctrl
    import quad_audio_mixer_pkg::*;
#(
    parameter int CH  = NUM_CH,
    parameter int DW  = WORD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_wr,
    input  logic          mod_wr,
    input  logic          pend_wr,
    input  logic [DW-1:0] wr_data,
    input  logic [CH-1:0] irq_req,
    output logic [CH-1:0] dma_en,
    output logic [CH-1:0] att_per,
    output logic [CH-1:0] att_vol,
    output logic [CH-1:0] pend
);
    localparam int PER_LO = CH;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dma_en  <= '0;
            att_per <= '0;
            att_vol <= '0;
            pend    <= '0;
        end else begin
            if (en_wr) dma_en <= wr_data[CH-1:0];
            if (mod_wr) begin
                att_per <= wr_data[PER_LO +: CH];
                att_vol <= wr_data[CH-1:0];
            end
            if (pend_wr) pend <= wr_data[CH-1:0] | irq_req;
            else         pend <= pend | irq_req;
        end
    end
endmodule

// File: rtl/quad_audio_mixer_pair.sv
module quad_audio_mixer_pair
    import quad_audio_mixer_pkg::*;
#(
    parameter int LW = LVL_W,
    parameter int SW = SMP_W,
    parameter int SH = SCALE_SH
) (
    input  logic signed [LW-1:0] lvl_a,
    input  logic signed [LW-1:0] lvl_b,
    input  logic                 gate_a,
    input  logic                 gate_b,
    output logic signed [SW-1:0] smp
);
    localparam int SUM_W = LW + 1;

    logic signed [SUM_W-1:0] ga, gb, sum;

    always_comb begin
        ga  = gate_a ? SUM_W'(lvl_a) : '0;
        gb  = gate_b ? SUM_W'(lvl_b) : '0;
        sum = ga + gb;
        smp = SW'(sum) <<< SH;
    end
endmodule

// File: rtl/quad_audio_mixer_seq.sv
module quad_audio_mixer_seq
    import quad_audio_mixer_pkg::*;
#(
    parameter int SW = SMP_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [SW-1:0] mix_l,
    input  logic [SW-1:0] mix_r,
    output logic [SW-1:0] left,
    output logic [SW-1:0] right,
    output logic          valid
);
    mix_state_t state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            MX_IDLE: if (tick) state_nx = MX_EMIT;
            MX_EMIT: state_nx = tick ? MX_EMIT : MX_IDLE;
            default: state_nx = MX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= MX_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left  <= '0;
            right <= '0;
        end else if (tick) begin
            left  <= mix_l;
            right <= mix_r;
        end
    end

    assign valid = (state == MX_EMIT);
endmodule

// File: rtl/quad_audio_mixer.sv
module quad_audio_mixer
    import quad_audio_mixer_pkg::*;
#(
    parameter int CH = NUM_CH,
    parameter int LW = LVL_W,
    parameter int SW = SMP_W,
    parameter int DW = WORD_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_wr,
    input  logic            mod_wr,
    input  logic            pend_wr,
    input  logic [DW-1:0]   wr_data,
    input  logic [CH-1:0]   irq_req,
    input  logic            tick,
    input  logic [CH*LW-1:0] levels,
    input  logic [CH-1:0]   gate,
    output logic [CH-1:0]   dma_en,
    output logic [CH-1:0]   att_per,
    output logic [CH-1:0]   att_vol,
    output logic [CH-1:0]   pend,
    output logic [CH-1:0]   per_from_up,
    output logic [CH-1:0]   vol_from_up,
    output logic [SW-1:0]   left,
    output logic [SW-1:0]   right,
    output logic            valid
);
    logic [LW-1:0] lvl [CH];
    logic [SW-1:0] mix_l, mix_r;

    quad_audio_mixer_ctrl #(.CH(CH), .DW(DW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .mod_wr(mod_wr),
        .pend_wr(pend_wr), .wr_data(wr_data), .irq_req(irq_req),
        .dma_en(dma_en), .att_per(att_per), .att_vol(att_vol), .pend(pend)
    );

    // Attach chain: each channel feeds the next one up; the last feeds nothing.
    genvar gi;
    generate
        for (gi = 0; gi < CH; gi++) begin : g_chan
            assign lvl[gi] = levels[gi*LW +: LW];
            if (gi == 0) begin : g_head
                assign per_from_up[gi] = 1'b0;
                assign vol_from_up[gi] = 1'b0;
            end else begin : g_link
                assign per_from_up[gi] = att_per[gi-1];
                assign vol_from_up[gi] = att_vol[gi-1];
            end
        end
    endgenerate

    // Cross-panned pairing: left takes 1 and 2, right takes 0 and 3.
    quad_audio_mixer_pair #(.LW(LW), .SW(SW)) u_left (
        .lvl_a(lvl[1]), .lvl_b(lvl[2]), .gate_a(gate[1]), .gate_b(gate[2]),
        .smp(mix_l)
    );
    quad_audio_mixer_pair #(.LW(LW), .SW(SW)) u_right (
        .lvl_a(lvl[0]), .lvl_b(lvl[3]), .gate_a(gate[0]), .gate_b(gate[3]),
        .smp(mix_r)
    );

    quad_audio_mixer_seq #(.SW(SW)) u_seq (
        .clk(clk), .rst_n(rst_n), .tick(tick), .mix_l(mix_l), .mix_r(mix_r),
        .left(left), .right(right), .valid(valid)
    );
endmodule

// File: rtl/quad_audio_mixer_chk.sv
module quad_audio_mixer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        en_wr,
    input logic        pend_wr,
    input logic [15:0] wr_data,
    input logic [3:0]  irq_req,
    input logic        tick,
    input logic [3:0]  dma_en,
    input logic [3:0]  att_per,
    input logic [3:0]  att_vol,
    input logic [3:0]  pend,
    input logic [3:0]  per_from_up,
    input logic [3:0]  vol_from_up,
    input logic [15:0] left,
    input logic [15:0] right,
    input logic        valid
);
    a_r2_enable_load: assert property (@(posedge clk) disable iff (!rst_n)
        en_wr |=> dma_en == $past(wr_data[3:0]));
    a_r6_request_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req != 4'd0) |=> ((pend & $past(irq_req)) == $past(irq_req)));
    a_r5_pend_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_wr && irq_req == 4'd0) |=> $stable(pend));
    a_r7_tick_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> valid);
    a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> !valid);
    a_r10_hold_samples: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> ($stable(left) && $stable(right)));
    a_r4_chain_head: assert property (@(posedge clk) disable iff (!rst_n)
        per_from_up[0] == 1'b0 && vol_from_up[0] == 1'b0);
    a_r4_chain_link: assert property (@(posedge clk) disable iff (!rst_n)
        per_from_up[3:1] == att_per[2:0] && vol_from_up[3:1] == att_vol[2:0]);
endmodule

bind quad_audio_mixer quad_audio_mixer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .pend_wr(pend_wr),
    .wr_data(wr_data), .irq_req(irq_req), .tick(tick), .dma_en(dma_en),
    .att_per(att_per), .att_vol(att_vol), .pend(pend),
    .per_from_up(per_from_up), .vol_from_up(vol_from_up),
    .left(left), .right(right), .valid(valid)
);

// File: tb/quad_audio_mixer_tb.sv
module quad_audio_mixer_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_wr = 1'b0, mod_wr = 1'b0, pend_wr = 1'b0;
    logic [15:0] wr_data = '0;
    logic [3:0]  irq_req = '0;
    logic        tick = 1'b0;
    logic [31:0] levels = '0;
    logic [3:0]  gate = '0;
    logic [3:0]  dma_en, att_per, att_vol, pend, per_from_up, vol_from_up;
    logic [15:0] left, right;
    logic        valid;

    int n_checks = 0;
    int n_fails  = 0;
    int n_valid  = 0;
    bit done     = 1'b0;
    logic [31:0] exp_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    quad_audio_mixer u_dut (
        .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .mod_wr(mod_wr),
        .pend_wr(pend_wr), .wr_data(wr_data), .irq_req(irq_req),
        .tick(tick), .levels(levels), .gate(gate), .dma_en(dma_en),
        .att_per(att_per), .att_vol(att_vol), .pend(pend),
        .per_from_up(per_from_up), .vol_from_up(vol_from_up),
        .left(left), .right(right), .valid(valid)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] pair_sum(input logic [7:0] a, input logic [7:0] b,
                                             input logic ga, input logic gb);
        int s;
        s = (ga ? int'($signed(a)) : 0) + (gb ? int'($signed(b)) : 0);
        return 16'(s * 128);
    endfunction

    // Driver: present one tick and push its expected pair.
    task automatic drive_tick(input logic [31:0] lv, input logic [3:0] g);
        levels = lv;
        gate   = g;
        tick   = 1'b1;
        exp_q.push_back({pair_sum(lv[15:8], lv[23:16], g[1], g[2]),
                         pair_sum(lv[7:0], lv[31:24], g[0], g[3])});
        @(negedge clk);
        tick = 1'b0;
    endtask

    // Monitor: compare each strobed pair against the scoreboard (R7, R8, R9, R11).
    always @(negedge clk) begin
        if (rst_n && valid) begin
            n_valid++;
            if (exp_q.size() == 0) check("R7 unexpected strobe", 32'd1, 32'd0);
            else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                check("R8 left", {16'd0, left}, {16'd0, e[31:16]});
                check("R9 right", {16'd0, right}, {16'd0, e[15:0]});
            end
        end
    end

    task automatic wr(input int which, input logic [15:0] d);
        wr_data = d;
        en_wr   = (which == 0);
        mod_wr  = (which == 1);
        pend_wr = (which == 2);
        @(negedge clk);
        en_wr = 1'b0; mod_wr = 1'b0; pend_wr = 1'b0;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        check("watchdog", 32'd1, 32'd0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 controls", {16'd0, dma_en, att_per, att_vol, pend}, 32'd0);
        check("R1 samples", {left, right}, 32'd0);
        check("R1 strobe", {31'd0, valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 enable write, upper bits ignored, others untouched
        wr(0, 16'hFFA5);
        check("R2 dma_en", {28'd0, dma_en}, 32'h5);
        check("R2 others unchanged", {20'd0, att_per, att_vol, pend}, 32'd0);

        // R3 / R4 attach flags and chain
        wr(1, 16'hAB9C);
        check("R3 att_per", {28'd0, att_per}, 32'h9);
        check("R3 att_vol", {28'd0, att_vol}, 32'hC);
        check("R4 per chain", {28'd0, per_from_up}, 32'h2);
        check("R4 vol chain", {28'd0, vol_from_up}, 32'h8);
        check("R2 dma_en held", {28'd0, dma_en}, 32'h5);
        wr(1, 16'h0088);
        check("R4 ch3 feeds nothing", {24'd0, per_from_up, vol_from_up}, 32'h00);

        // R5 pending write
        wr(2, 16'hFFF6);
        check("R5 pend load", {28'd0, pend}, 32'h6);

        // R6 request sets and holds
        irq_req = 4'b1000;
        @(negedge clk);
        irq_req = 4'b0000;
        check("R6 request sets", {28'd0, pend}, 32'hE);
        @(negedge clk);
        check("R6 flag holds", {28'd0, pend}, 32'hE);
        // R6 same-cycle write and request: request wins
        wr_data = 16'h0000; pend_wr = 1'b1; irq_req = 4'b0001;
        @(negedge clk);
        pend_wr = 1'b0; irq_req = 4'b0000;
        check("R6 request beats write", {28'd0, pend}, 32'h1);
        wr(2, 16'h0000);
        check("R5 pend clear", {28'd0, pend}, 32'h0);

        // R8 / R9 mixing patterns
        drive_tick({8'd10, 8'd20, 8'd30, 8'd40}, 4'b1111);
        @(negedge clk);
        drive_tick({8'hF6, 8'd20, 8'hE2, 8'd40}, 4'b0110);
        @(negedge clk);
        drive_tick({8'd5, 8'd6, 8'd7, 8'd8}, 4'b0000);
        @(negedge clk);
        // R7 back-to-back ticks
        drive_tick({8'd1, 8'd2, 8'd3, 8'd4}, 4'b1001);
        drive_tick({8'hFF, 8'hFE, 8'hFD, 8'hFC}, 4'b1111);
        @(negedge clk);
        // R10 hold between strobes
        levels = 32'h7F7F7F7F; gate = 4'b1111;
        repeat (2) @(negedge clk);
        check("R10 hold", {left, right}, {pair_sum(8'hFE, 8'hFD, 1, 1), pair_sum(8'hFC, 8'hFF, 1, 1)});
        // R11 extremes
        drive_tick(32'h80808080, 4'b1111);
        @(negedge clk);
        drive_tick(32'h7F7F7F7F, 4'b1111);
        @(negedge clk);
        check("R11 min value seen", {16'd0, pair_sum(8'h80, 8'h80, 1, 1)}, 32'h8000);
        check("R11 max", {left, right}, 32'h7F007F00);
        // R7 strobe count equals tick count, queue drained
        repeat (3) @(negedge clk);
        check("R7 strobe count", n_valid, 32'd7);
        check("R7 queue drained", exp_q.size(), 32'd0);
        finish_run();
    end
endmodule